// File: doc/BRIEF.md
# Strobe Window Compare and Failing-Vector Logger

This block sits behind the two comparator outputs of one tester pin and runs in the pattern clock domain. Each vector begins with a one-cycle `vec_start_i` pulse. At that pulse the block latches the vector's expect opcode, its address, the chosen strobe window, the capture-edge choice and the record mode. A tick counter then counts pattern clock cycles inside the vector. When it reaches the open or close tick of the chosen window, the comparator pair is sampled once.

The sample is sorted into one of three classes: good-1 (above the high threshold), good-0 (below the low threshold) or an invalid mid-band level. The class is then judged against the expect opcode, or passed through as raw data, according to the record mode. The block produces a failing-vector pulse and a sticky fail flag. Failing vector addresses are kept in an error memory, together with a count, an overflow flag and a registered read port.

Top module: `pin_window_compare`

## Requirements
- R1: After reset, cap_valid_o, vec_fail_o, fail_sticky_o, raw_data_o, err_cnt_o and err_ovf_o are all zero.
- R2: With cap_mode 1 (opening edge), the pin is sampled once, in the cycle whose tick count, counted from 0 in the cycle after the `vec_start_i` cycle, equals the open tick of the window chosen by win_sel_i. Window w takes bits [w*TICK_W +: TICK_W] of win_open_i and win_close_i. cap_valid_o pulses in the following cycle.
- R3: With cap_mode 2 (closing edge), the single sample is taken at the close tick of the chosen window instead.
- R4: With cap_mode 0 or 3 (masked), no sample is taken, so there is no cap_valid_o, no fail and no error record for that vector.
- R5: The sample is good-1 when hi=1 and lo=0. It is good-0 when lo=1 and hi=0. Any other pair is mid-band. In record mode 0 the opcodes judge as follows: 0 never fails; 1 (sense low) fails unless good-0; 2 (sense high) fails unless good-1; 3 (valid) fails on mid-band; 4 (invalid) fails unless mid-band. A failure shows as vec_fail_o together with cap_valid_o.
- R6: Opcode 5 reuses the previous vector's resolved opcode. Opcode 6 uses its inverse: 1 and 2 swap, 3 and 4 swap, and 0 stays 0. Opcode 7 acts as 0. The state after reset is 0.
- R7: In record mode 1 only good-1 counts as a high. Opcode 2 fails unless good-1, opcode 1 fails on good-1, and the other opcodes never fail.
- R8: Record modes 2, 3 and 4 never fail. On each sample they load raw_data_o with {0, not good-0}, {0, good-1} and {good-1, good-0} respectively. In compare modes raw_data_o holds its value.
- R9: Each failing vector's address is written at index err_cnt_o and err_cnt_o then increments, one cycle after vec_fail_o. rd_data_o returns entry rd_addr_i one cycle after the address is applied.
- R10: Once err_cnt_o equals ERR_DEPTH, further failing addresses are dropped and err_cnt_o holds. err_ovf_o is set and stays set.
- R11: fail_sticky_o sets one cycle after any vec_fail_o, including one that arrives after overflow, and stays set until reset.
- R12: A vector samples at most once. If the vector ends before the target tick is reached, no sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pattern clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_start_i | input | 1 | First cycle of a vector; latches the vector fields |
| vec_addr_i | input | ADDR_W | Vector address |
| exp_op_i | input | 3 | Expect opcode |
| win_sel_i | input | WSEL_W | Strobe window index |
| cap_mode_i | input | 2 | 0/3 masked, 1 opening edge, 2 closing edge |
| rec_mode_i | input | 3 | 0 compare both, 1 compare good-1 only, 2/3/4 raw record |
| win_open_i | input | NWIN*TICK_W | Open tick of each window |
| win_close_i | input | NWIN*TICK_W | Close tick of each window |
| cmp_hi_i | input | 1 | High comparator: above the high threshold |
| cmp_lo_i | input | 1 | Low comparator: below the low threshold |
| rd_addr_i | input | IDX_W | Error memory read index |
| cap_valid_o | output | 1 | Pulse: a sample was taken |
| vec_fail_o | output | 1 | Pulse: the sample failed |
| fail_sticky_o | output | 1 | Any failure since reset |
| raw_data_o | output | 2 | Raw record data |
| err_cnt_o | output | CNT_W | Number of stored failing addresses |
| err_ovf_o | output | 1 | A failing address was dropped |
| rd_data_o | output | ADDR_W | Error memory read data |

## Verification
The bench builds the block with ERR_DEPTH=4, so a handful of failing vectors fills the error memory and the overflow drop and the sticky-flag update past overflow are both reached. NWIN=4 and TICK_W=4 keep every window tick short. The comparator pair switches level at tick 4, so the open and close edges of one window see different classes, and windows whose edges fall on either side of the switch can be told apart. A short vector against a late close tick shows the unreached-strobe case.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_LO      = 3'd1,
    OP_HI      = 3'd2,
    OP_VALID   = 3'd3,
    OP_INVALID = 3'd4,
    OP_REPEAT  = 3'd5,
    OP_INVERT  = 3'd6,
    OP_RSVD    = 3'd7
  } exp_op_e;

  typedef enum logic [1:0] {
    CAP_OFF   = 2'd0,
    CAP_OPEN  = 2'd1,
    CAP_CLOSE = 2'd2,
    CAP_OFF2  = 2'd3
  } cap_mode_e;

  typedef enum logic [2:0] {
    REC_CMP_BOTH = 3'd0,
    REC_CMP_G1   = 3'd1,
    REC_RAW_NG0  = 3'd2,
    REC_RAW_G1   = 3'd3,
    REC_RAW_BOTH = 3'd4
  } rec_mode_e;

  function automatic exp_op_e invert_op(exp_op_e op);
    case (op)
      OP_LO:      return OP_HI;
      OP_HI:      return OP_LO;
      OP_VALID:   return OP_INVALID;
      OP_INVALID: return OP_VALID;
      default:    return OP_NONE;
    endcase
  endfunction

  // repeat/invert resolve against the last concrete opcode
  function automatic exp_op_e resolve_op(exp_op_e op, exp_op_e prev);
    case (op)
      OP_REPEAT: return prev;
      OP_INVERT: return invert_op(prev);
      OP_RSVD:   return OP_NONE;
      default:   return op;
    endcase
  endfunction

endpackage

// File: rtl/wcmp_strobe_timer.sv
module wcmp_strobe_timer import wcmp_pkg::*; #(
  parameter int NWIN   = 4,
  parameter int TICK_W = 6,
  localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vec_start_i,
  input  logic [WSEL_W-1:0]      win_sel_i,
  input  logic [1:0]             cap_mode_i,
  input  logic [NWIN*TICK_W-1:0] win_open_i,
  input  logic [NWIN*TICK_W-1:0] win_close_i,
  output logic                   strobe_o
);

  logic [TICK_W-1:0] open_tab  [NWIN];
  logic [TICK_W-1:0] close_tab [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign open_tab[w]  = win_open_i[w*TICK_W +: TICK_W];
    assign close_tab[w] = win_close_i[w*TICK_W +: TICK_W];
  end

  logic [TICK_W-1:0] tick_q, target_q;
  logic              armed_q;
  cap_mode_e         mode;

  assign mode     = cap_mode_e'(cap_mode_i);
  assign strobe_o = armed_q && (tick_q == target_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= '0;
      target_q <= '0;
      armed_q  <= 1'b0;
    end else if (vec_start_i) begin
      tick_q   <= '0;
      target_q <= (mode == CAP_CLOSE) ? close_tab[win_sel_i] : open_tab[win_sel_i];
      armed_q  <= (mode == CAP_OPEN) || (mode == CAP_CLOSE);
    end else begin
      if (tick_q != '1) tick_q <= tick_q + TICK_W'(1);
      if (strobe_o) armed_q <= 1'b0;
    end
  end

endmodule

// File: rtl/wcmp_expect_eval.sv
module wcmp_expect_eval import wcmp_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vec_start_i,
  input  logic [2:0] exp_op_i,
  input  logic [2:0] rec_mode_i,
  input  logic       strobe_i,
  input  logic       cmp_hi_i,
  input  logic       cmp_lo_i,
  output logic       cap_o,
  output logic       fail_o,
  output logic [1:0] raw_o
);

  exp_op_e   op_q;
  rec_mode_e rec_q;
  logic      good1, good0, mid;
  logic      fail_both, fail_g1, is_raw, fail_now;
  logic [1:0] raw_now;

  assign good1 = cmp_hi_i & ~cmp_lo_i;
  assign good0 = cmp_lo_i & ~cmp_hi_i;
  assign mid   = ~(good1 | good0);

  always_comb begin
    case (op_q)
      OP_LO:      fail_both = ~good0;
      OP_HI:      fail_both = ~good1;
      OP_VALID:   fail_both = mid;
      OP_INVALID: fail_both = ~mid;
      default:    fail_both = 1'b0;
    endcase
    case (op_q)
      OP_LO:   fail_g1 = good1;
      OP_HI:   fail_g1 = ~good1;
      default: fail_g1 = 1'b0;
    endcase
  end

  always_comb begin
    is_raw  = 1'b1;
    raw_now = 2'b00;
    case (rec_q)
      REC_RAW_NG0:  raw_now = {1'b0, ~good0};
      REC_RAW_G1:   raw_now = {1'b0, good1};
      REC_RAW_BOTH: raw_now = {good1, good0};
      default:      is_raw  = 1'b0;
    endcase
  end

  assign fail_now = (rec_q == REC_CMP_G1) ? fail_g1 : (!is_raw && fail_both);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      rec_q  <= REC_CMP_BOTH;
      cap_o  <= 1'b0;
      fail_o <= 1'b0;
      raw_o  <= 2'b00;
    end else begin
      if (vec_start_i) begin
        op_q  <= resolve_op(exp_op_e'(exp_op_i), op_q);
        rec_q <= rec_mode_e'(rec_mode_i);
      end
      cap_o  <= strobe_i;
      fail_o <= strobe_i && fail_now;
      if (strobe_i && is_raw) raw_o <= raw_now;
    end
  end

endmodule

// File: rtl/wcmp_err_log.sv
module wcmp_err_log #(
  parameter int ERR_DEPTH = 1024,
  parameter int ADDR_W    = 16,
  localparam int IDX_W = $clog2(ERR_DEPTH),
  localparam int CNT_W = $clog2(ERR_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  output logic              sticky_o
);

  logic [ADDR_W-1:0] mem_q [ERR_DEPTH];
  logic              room;

  assign room = cnt_o < CNT_W'(ERR_DEPTH);

  always_ff @(posedge clk_i) begin
    if (wr_i && room) mem_q[cnt_o[IDX_W-1:0]] <= wr_addr_i;
    rd_data_o <= mem_q[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      ovf_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else if (wr_i) begin
      sticky_o <= 1'b1;
      if (room) cnt_o <= cnt_o + CNT_W'(1);
      else      ovf_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pin_window_compare.sv
module pin_window_compare import wcmp_pkg::*; #(
  parameter int NWIN      = 4,
  parameter int TICK_W    = 6,
  parameter int ADDR_W    = 16,
  parameter int ERR_DEPTH = 1024,
  localparam int WSEL_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int IDX_W  = $clog2(ERR_DEPTH),
  localparam int CNT_W  = $clog2(ERR_DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vec_start_i,
  input  logic [ADDR_W-1:0]      vec_addr_i,
  input  logic [2:0]             exp_op_i,
  input  logic [WSEL_W-1:0]      win_sel_i,
  input  logic [1:0]             cap_mode_i,
  input  logic [2:0]             rec_mode_i,
  input  logic [NWIN*TICK_W-1:0] win_open_i,
  input  logic [NWIN*TICK_W-1:0] win_close_i,
  input  logic                   cmp_hi_i,
  input  logic                   cmp_lo_i,
  input  logic [IDX_W-1:0]       rd_addr_i,
  output logic                   cap_valid_o,
  output logic                   vec_fail_o,
  output logic                   fail_sticky_o,
  output logic [1:0]             raw_data_o,
  output logic [CNT_W-1:0]       err_cnt_o,
  output logic                   err_ovf_o,
  output logic [ADDR_W-1:0]      rd_data_o
);

  logic              strobe;
  logic [ADDR_W-1:0] addr_q, fail_addr_q;

  // address follows the sample so a log write never sees the next vector
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q      <= '0;
      fail_addr_q <= '0;
    end else begin
      if (vec_start_i) addr_q <= vec_addr_i;
      if (strobe)      fail_addr_q <= addr_q;
    end
  end

  wcmp_strobe_timer #(.NWIN(NWIN), .TICK_W(TICK_W)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vec_start_i (vec_start_i),
    .win_sel_i   (win_sel_i),
    .cap_mode_i  (cap_mode_i),
    .win_open_i  (win_open_i),
    .win_close_i (win_close_i),
    .strobe_o    (strobe)
  );

  wcmp_expect_eval i_eval (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vec_start_i (vec_start_i),
    .exp_op_i    (exp_op_i),
    .rec_mode_i  (rec_mode_i),
    .strobe_i    (strobe),
    .cmp_hi_i    (cmp_hi_i),
    .cmp_lo_i    (cmp_lo_i),
    .cap_o       (cap_valid_o),
    .fail_o      (vec_fail_o),
    .raw_o       (raw_data_o)
  );

  wcmp_err_log #(.ERR_DEPTH(ERR_DEPTH), .ADDR_W(ADDR_W)) i_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (vec_fail_o),
    .wr_addr_i (fail_addr_q),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .cnt_o     (err_cnt_o),
    .ovf_o     (err_ovf_o),
    .sticky_o  (fail_sticky_o)
  );

endmodule

// File: rtl/wcmp_checker.sv
module wcmp_checker #(
  parameter int ERR_DEPTH = 1024,
  parameter int CNT_W     = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cap_valid_o,
  input logic             vec_fail_o,
  input logic             fail_sticky_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             err_ovf_o
);

  p_fail_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fail_o |-> cap_valid_o);

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_cnt_o) |-> ($past(vec_fail_o) && err_cnt_o == $past(err_cnt_o) + CNT_W'(1)));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovf_o |-> err_cnt_o == CNT_W'(ERR_DEPTH));

  p_ovf_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ovf_o |=> err_ovf_o);

  p_sticky_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fail_o |=> fail_sticky_o);

  p_sticky_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_sticky_o |=> fail_sticky_o);

endmodule

bind pin_window_compare wcmp_checker #(.ERR_DEPTH(ERR_DEPTH), .CNT_W(CNT_W)) i_wcmp_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cap_valid_o   (cap_valid_o),
  .vec_fail_o    (vec_fail_o),
  .fail_sticky_o (fail_sticky_o),
  .err_cnt_o     (err_cnt_o),
  .err_ovf_o     (err_ovf_o)
);

// File: tb/test_pin_window_compare.sv
module test_pin_window_compare;
  localparam int NWIN = 4, TICK_W = 4, ADDR_W = 8, DEPTH = 4;
  localparam logic [1:0] G1 = 2'b10, G0 = 2'b01, MID = 2'b00, BOTH = 2'b11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic vec_start = 1'b0;
  logic [ADDR_W-1:0] vec_addr = '0;
  logic [2:0] exp_op = '0, rec_mode = '0;
  logic [1:0] win_sel = '0, cap_mode = '0;
  logic cmp_hi = 1'b0, cmp_lo = 1'b0;
  logic [1:0] rd_addr = '0;
  logic cap_valid, vec_fail, sticky, ovf;
  logic [1:0] raw;
  logic [2:0] cnt;
  logic [ADDR_W-1:0] rd_data;

  // open ticks w3..w0 = 1,5,3,2 ; close ticks = 4,9,7,6
  wire [NWIN*TICK_W-1:0] win_open  = {4'd1, 4'd5, 4'd3, 4'd2};
  wire [NWIN*TICK_W-1:0] win_close = {4'd4, 4'd9, 4'd7, 4'd6};

  int total = 0, bad = 0;
  int exp_cnt = 0;
  logic exp_ovf = 1'b0, exp_sticky = 1'b0;
  logic [ADDR_W-1:0] exp_mem [DEPTH];

  always #5ns clk = ~clk;

  pin_window_compare #(.NWIN(NWIN), .TICK_W(TICK_W), .ADDR_W(ADDR_W), .ERR_DEPTH(DEPTH))
    i_pin_window_compare (
    .clk_i(clk), .rst_ni(rst_ni), .vec_start_i(vec_start), .vec_addr_i(vec_addr),
    .exp_op_i(exp_op), .win_sel_i(win_sel), .cap_mode_i(cap_mode), .rec_mode_i(rec_mode),
    .win_open_i(win_open), .win_close_i(win_close), .cmp_hi_i(cmp_hi), .cmp_lo_i(cmp_lo),
    .rd_addr_i(rd_addr), .cap_valid_o(cap_valid), .vec_fail_o(vec_fail),
    .fail_sticky_o(sticky), .raw_data_o(raw), .err_cnt_o(cnt), .err_ovf_o(ovf),
    .rd_data_o(rd_data));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // comparators carry level a for ticks 0..3 and level b from tick 4 on
  task automatic run_vec(string req, logic [2:0] op, logic [ADDR_W-1:0] addr, logic [1:0] cm,
                         logic [2:0] rm, logic [1:0] ws, logic [1:0] a, logic [1:0] b,
                         int len, int exp_cap, int exp_fail, bit chk_raw, logic [1:0] exp_raw);
    int caps = 0, fails = 0;
    @(negedge clk);
    vec_start = 1'b1; exp_op = op; vec_addr = addr; cap_mode = cm; rec_mode = rm; win_sel = ws;
    @(negedge clk);
    vec_start = 1'b0;
    for (int t = 0; t < len; t++) begin
      {cmp_hi, cmp_lo} = (t < 4) ? a : b;
      @(negedge clk);
      if (cap_valid) caps++;
      if (vec_fail) fails++;
    end
    if (exp_fail != 0) begin
      exp_sticky = 1'b1;
      if (exp_cnt < DEPTH) begin exp_mem[exp_cnt] = addr; exp_cnt++; end
      else exp_ovf = 1'b1;
    end
    check({req, " samples"}, caps, exp_cap);
    check({req, " fail"}, fails, exp_fail);
    check({req, " R9 count"}, int'(cnt), exp_cnt);
    check({req, " R10 ovf"}, int'(ovf), int'(exp_ovf));
    check({req, " R11 sticky"}, int'(sticky), int'(exp_sticky));
    if (chk_raw) check({req, " raw"}, int'(raw), int'(exp_raw));
  endtask

  task automatic t_reset;
    check("R1 cap", int'(cap_valid), 0);
    check("R1 fail", int'(vec_fail), 0);
    check("R1 sticky", int'(sticky), 0);
    check("R1 raw", int'(raw), 0);
    check("R1 cnt", int'(cnt), 0);
    check("R1 ovf", int'(ovf), 0);
  endtask

  task automatic t_edges;
    run_vec("R2 open w0", 3'd2, 8'h10, 2'd1, 3'd0, 2'd0, G1, G0, 12, 1, 0, 0, 2'b00);
    run_vec("R3 close w0", 3'd2, 8'h11, 2'd2, 3'd0, 2'd0, G1, G0, 12, 1, 1, 0, 2'b00);
    run_vec("R2 open w3", 3'd1, 8'h20, 2'd1, 3'd0, 2'd3, G0, G1, 12, 1, 0, 0, 2'b00);
    run_vec("R2 open w2", 3'd1, 8'h22, 2'd1, 3'd0, 2'd2, G0, G1, 12, 1, 1, 0, 2'b00);
    run_vec("R3 close w1", 3'd2, 8'h23, 2'd2, 3'd0, 2'd1, G0, G1, 12, 1, 0, 0, 2'b00);
  endtask

  task automatic t_mask;
    run_vec("R4 mask0", 3'd2, 8'h30, 2'd0, 3'd0, 2'd0, G0, G0, 12, 0, 0, 0, 2'b00);
    run_vec("R4 mask3", 3'd2, 8'h31, 2'd3, 3'd0, 2'd0, G0, G0, 12, 0, 0, 0, 2'b00);
  endtask

  task automatic t_classify;
    run_vec("R5 valid mid", 3'd3, 8'h40, 2'd1, 3'd0, 2'd0, MID, MID, 12, 1, 1, 0, 2'b00);
    run_vec("R5 valid g0", 3'd3, 8'h41, 2'd1, 3'd0, 2'd0, G0, G0, 12, 1, 0, 0, 2'b00);
    run_vec("R5 invalid mid", 3'd4, 8'h42, 2'd1, 3'd0, 2'd0, MID, MID, 12, 1, 0, 0, 2'b00);
    run_vec("R5 invalid g1", 3'd4, 8'h43, 2'd1, 3'd0, 2'd0, G1, G1, 12, 1, 1, 0, 2'b00);
    run_vec("R5 invalid both", 3'd4, 8'h44, 2'd1, 3'd0, 2'd0, BOTH, BOTH, 12, 1, 0, 0, 2'b00);
    run_vec("R5 none mid", 3'd0, 8'h45, 2'd1, 3'd0, 2'd0, MID, MID, 12, 1, 0, 0, 2'b00);
    run_vec("R5 lo mid", 3'd1, 8'h46, 2'd1, 3'd0, 2'd0, MID, MID, 12, 1, 1, 0, 2'b00);
  endtask

  task automatic t_ops;
    run_vec("R6 hi", 3'd2, 8'h50, 2'd1, 3'd0, 2'd0, G1, G1, 12, 1, 0, 0, 2'b00);
    run_vec("R6 repeat", 3'd5, 8'h51, 2'd1, 3'd0, 2'd0, G0, G0, 12, 1, 1, 0, 2'b00);
    run_vec("R6 invert lo", 3'd6, 8'h52, 2'd1, 3'd0, 2'd0, G0, G0, 12, 1, 0, 0, 2'b00);
    run_vec("R6 invert hi", 3'd6, 8'h53, 2'd1, 3'd0, 2'd0, G0, G0, 12, 1, 1, 0, 2'b00);
    run_vec("R6 rsvd", 3'd7, 8'h54, 2'd1, 3'd0, 2'd0, MID, MID, 12, 1, 0, 0, 2'b00);
    run_vec("R6 invert none", 3'd6, 8'h55, 2'd1, 3'd0, 2'd0, MID, MID, 12, 1, 0, 0, 2'b00);
  endtask

  task automatic t_g1only;
    run_vec("R7 lo mid", 3'd1, 8'h60, 2'd1, 3'd1, 2'd0, MID, MID, 12, 1, 0, 0, 2'b00);
    run_vec("R7 hi mid", 3'd2, 8'h61, 2'd1, 3'd1, 2'd0, MID, MID, 12, 1, 1, 0, 2'b00);
    run_vec("R7 valid mid", 3'd3, 8'h62, 2'd1, 3'd1, 2'd0, MID, MID, 12, 1, 0, 0, 2'b00);
    run_vec("R7 invalid g1", 3'd4, 8'h63, 2'd1, 3'd1, 2'd0, G1, G1, 12, 1, 0, 0, 2'b00);
    run_vec("R7 lo g1", 3'd1, 8'h64, 2'd1, 3'd1, 2'd0, G1, G1, 12, 1, 1, 0, 2'b00);
  endtask

  task automatic t_raw;
    run_vec("R8 ng0 g0", 3'd2, 8'h70, 2'd1, 3'd2, 2'd0, G0, G0, 12, 1, 0, 1, 2'b00);
    run_vec("R8 ng0 mid", 3'd2, 8'h71, 2'd1, 3'd2, 2'd0, MID, MID, 12, 1, 0, 1, 2'b01);
    run_vec("R8 g1 g1", 3'd2, 8'h72, 2'd1, 3'd3, 2'd0, G1, G1, 12, 1, 0, 1, 2'b01);
    run_vec("R8 g1 mid", 3'd2, 8'h73, 2'd1, 3'd3, 2'd0, MID, MID, 12, 1, 0, 1, 2'b00);
    run_vec("R8 both g1", 3'd2, 8'h74, 2'd1, 3'd4, 2'd0, G1, G1, 12, 1, 0, 1, 2'b10);
    run_vec("R8 both g0", 3'd2, 8'h75, 2'd1, 3'd4, 2'd0, G0, G0, 12, 1, 0, 1, 2'b01);
    run_vec("R8 cmp hold", 3'd2, 8'h76, 2'd1, 3'd0, 2'd0, G1, G1, 12, 1, 0, 1, 2'b01);
  endtask

  task automatic t_miss;
    run_vec("R12 unreached", 3'd2, 8'h80, 2'd2, 3'd0, 2'd2, G0, G0, 4, 0, 0, 0, 2'b00);
    run_vec("R12 single", 3'd2, 8'h81, 2'd1, 3'd0, 2'd3, G0, G0, 12, 1, 1, 0, 2'b00);
  endtask

  task automatic t_overflow;
    run_vec("R10 drop a", 3'd1, 8'h90, 2'd1, 3'd0, 2'd0, G1, G1, 12, 1, 1, 0, 2'b00);
    run_vec("R10 drop b", 3'd1, 8'h91, 2'd1, 3'd0, 2'd0, G1, G1, 12, 1, 1, 0, 2'b00);
    check("R10 count held", int'(cnt), DEPTH);
    check("R10 ovf set", int'(ovf), 1);
  endtask

  task automatic t_readback;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rd_addr = 2'(i);
      @(negedge clk);
      check($sformatf("R9 entry %0d", i), int'(rd_data), int'(exp_mem[i]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_edges();
    t_mask();
    t_classify();
    t_ops();
    t_g1only();
    t_raw();
    t_miss();
    t_overflow();
    t_readback();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule